// File: doc/BRIEF.md
# I2C Channel-Select Switch Controller

The block is an I2C target that owns an 8-bit channel-enable register and drives one enable output per downstream channel. It watches SCL and SDA through synchronisers on a system clock that runs at least eight times faster than SCL. It recognises START and STOP, compares the 7-bit address with a parameter, and acknowledges a match. The SDA pin is open-drain and is modelled as an output enable that pulls the line low.

A write stores each received byte as a pending selection. If several bytes arrive, the last one wins. The pending value reaches the enable outputs only when a STOP is seen, so the downstream channels are switched while the bus is idle. A repeated START does not apply the pending value. A read returns the value that is currently applied. Mapping is direct: bit n of the register enables channel n, and any mix of channels may be on at the same time.

Top module: `i2c_chan_sel`

## Requirements
- R1: After reset `chan_en_o` is 0x00 (no channel enabled) and `sda_oe_o` is low.
- R2: The first byte after START is received MSB first: 7 address bits, then a R/W bit (0 = write, 1 = read). When the address equals `TGT_ADDR` (default 0x70), the block pulls SDA low (`sda_oe_o` high) for the whole 9th SCL pulse.
- R3: A non-matching address is not acknowledged. All further bytes up to the next START are neither acknowledged nor stored, and a STOP after them leaves `chan_en_o` unchanged.
- R4: Every written data byte is acknowledged on its 9th SCL pulse. `chan_en_o` keeps its old value until a STOP is detected, then takes the new value in a single step.
- R5: Bit n of the written byte drives `chan_en_o[n]` (1 = enabled). Any combination is accepted, including 0x00 and 0xFF.
- R6: When a write carries several data bytes, only the last one is applied at the STOP.
- R7: A repeated START does not apply the pending value. The next STOP applies it.
- R8: A read returns the applied register value MSB first, one bit per SCL pulse. A controller ACK repeats the value in the next byte. A controller NACK releases SDA, and the block does not drive it again until the next START.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. `sda_oe_o` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line, as seen on the wired bus |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| chan_en_o | output | NUM_CH | Applied per-channel enables |

## Verification
Directed writes of 0xA5, 0xFF and 0x00 check that each bit lands on its own channel. A three-byte write checks that the last byte wins, and a write under a wrong address checks that the traffic is ignored. A write followed by a repeated START and a read separates the pending value from the applied one: the read must return the old selection and the outputs must stay put until the STOP. Random transactions then mix byte counts, matching and non-matching addresses, and STOP versus repeated-START endings. A bench reference model of the pending and applied values checks the acknowledge bits, the read data and the outputs after each transaction.

// File: rtl/i2c_chan_sel_pkg.sv
package i2c_chan_sel_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } state_e;
endpackage

// File: rtl/i2c_chan_sel_sync.sv
module i2c_chan_sel_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '1;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '1;
      else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_chan_sel_cond.sv
module i2c_chan_sel_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/i2c_chan_sel_regs.sv
module i2c_chan_sel_regs #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [NUM_CH-1:0] wr_data_i,
  input  logic              stop_i,
  output logic [NUM_CH-1:0] chan_o
);
  logic [NUM_CH-1:0] pend_q;
  logic              pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      chan_o     <= '0;
    end else if (stop_i) begin
      if (pend_vld_q) chan_o <= pend_q;
      pend_vld_q <= 1'b0;
    end else if (wr_i) begin
      pend_q     <= wr_data_i;  // last byte wins
      pend_vld_q <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_chan_sel_fsm.sv
module i2c_chan_sel_fsm
  import i2c_chan_sel_pkg::*;
#(
  parameter logic [ADDR_W-1:0] TGT_ADDR = 7'h70
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o,
  output state_e            state_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  state_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] tx_q;
  logic              rw_q;
  logic              flag_q;  // ack phase marker / controller ACK seen

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      flag_q    <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_o      <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        flag_q   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise_i) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              if (sh_q[ADDR_W-1:0] == TGT_ADDR) begin
                rw_q    <= sda_i;
                flag_q  <= 1'b0;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            if (!flag_q) begin
              sda_oe_o <= 1'b1;
              flag_q   <= 1'b1;
            end else begin
              flag_q <= 1'b0;
              cnt_q  <= '0;
              if (rw_q) begin
                state_q  <= ST_RD;
                tx_q     <= rd_data_i;
                sda_oe_o <= !rd_data_i[BYTE_W-1];
              end else begin
                state_q  <= ST_WR;
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_WR: if (scl_rise_i) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              wr_o      <= 1'b1;
              wr_data_o <= {sh_q[BYTE_W-2:0], sda_i};
              flag_q    <= 1'b0;
              state_q   <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: if (scl_fall_i) begin
            if (!flag_q) begin
              sda_oe_o <= 1'b1;
              flag_q   <= 1'b1;
            end else begin
              sda_oe_o <= 1'b0;
              flag_q   <= 1'b0;
              cnt_q    <= '0;
              state_q  <= ST_WR;
            end
          end
          ST_RD: if (scl_fall_i) begin
            if (cnt_q == LAST_BIT) begin
              sda_oe_o <= 1'b0;
              flag_q   <= 1'b0;
              state_q  <= ST_RD_ACK;
            end else begin
              tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
              sda_oe_o <= !tx_q[BYTE_W-2];
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) flag_q <= !sda_i;
            else if (scl_fall_i) begin
              if (flag_q) begin
                state_q  <= ST_RD;
                tx_q     <= rd_data_i;
                sda_oe_o <= !rd_data_i[BYTE_W-1];
                cnt_q    <= '0;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel
  import i2c_chan_sel_pkg::*;
#(
  parameter logic [ADDR_W-1:0] TGT_ADDR = 7'h70,
  parameter int                NUM_CH   = BYTE_W,
  parameter int                SYNC_LEN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NUM_CH-1:0] chan_en_o
);
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_byte;
  state_e            state;

  i2c_chan_sel_sync #(.WIDTH(2), .STAGES(SYNC_LEN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_chan_sel_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_chan_sel_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_i     (sda_s),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .rd_data_i (chan_en_o),
    .wr_o      (wr_stb),
    .wr_data_o (wr_byte),
    .sda_oe_o  (sda_oe_o),
    .state_o   (state)
  );

  i2c_chan_sel_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_stb),
    .wr_data_i(wr_byte),
    .stop_i   (stop_det),
    .chan_o   (chan_en_o)
  );
endmodule

// File: rtl/i2c_chan_sel_chk.sv
module i2c_chan_sel_chk
  import i2c_chan_sel_pkg::*;
#(
  parameter int NUM_CH = BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_i,
  input logic [NUM_CH-1:0] chan_en_i,
  input logic              scl_s_i,
  input logic              start_i,
  input logic              stop_i,
  input state_e            state_i
);
  assert_apply_on_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_en_i) |-> $past(stop_i));

  assert_sda_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !$past(scl_s_i));

  assert_ignore_silent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IGNORE) |-> !sda_oe_i);

  assert_rd_ack_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RD_ACK) |-> !sda_oe_i);

  assert_restart_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_i == ST_ADDR));
endmodule

bind i2c_chan_sel i2c_chan_sel_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sda_oe_i (sda_oe_o),
  .chan_en_i(chan_en_o),
  .scl_s_i  (scl_s),
  .start_i  (start_det),
  .stop_i   (stop_det),
  .state_i  (state)
);

// File: tb/i2c_chan_sel_bench.sv
module i2c_chan_sel_bench;
  localparam logic [6:0] TGT = 7'h70;
  localparam int HP = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] chan_en;
  logic       sda_bus;

  int n_chk = 0;
  int n_fail = 0;
  int n_r9_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_app = 8'h00;
  logic [7:0] exp_pend = 8'h00;
  logic       exp_vld = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_chan_sel u_i2c_chan_sel (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .chan_en_o(chan_en)
  );

  // R9: open-drain driver may only move while SCL is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) n_r9_bad++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    sda_m = 1'b0; half();
    scl_m = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half();
    if (exp_vld) exp_app = exp_pend;
    exp_vld = 1'b0;
  endtask

  task automatic clk_bit(input logic b, output logic smp);
    sda_m = b; half();
    scl_m = 1'b1;
    repeat (HP - 1) @(negedge clk);
    smp = sda_bus;
    @(negedge clk);
    scl_m = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic more, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~more, s);
    sda_m = 1'b1;
  endtask

  task automatic write_txn(input logic [6:0] addr, input int n, input logic [23:0] data,
                           input logic end_stop);
    logic ack;
    logic match;
    match = (addr == TGT);
    bus_start();
    write_byte({addr, 1'b0}, ack);
    chk(match ? "R2 addr ack" : "R3 addr nack", ack, match);
    for (int i = 0; i < n; i++) begin
      write_byte(data[8*i +: 8], ack);
      chk(match ? "R4 data ack" : "R3 data ignored", ack, match);
      if (match) begin
        exp_pend = data[8*i +: 8];
        exp_vld = 1'b1;
      end
    end
    chk("R4 held before stop", chan_en, exp_app);
    if (end_stop) begin
      bus_stop();
      chk("R4 R6 applied at stop", chan_en, exp_app);
    end
  endtask

  task automatic read_txn(input int n, input logic end_stop);
    logic ack;
    logic [7:0] b;
    bus_start();
    write_byte({TGT, 1'b1}, ack);
    chk("R2 read addr ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      read_byte(i < n - 1, b);
      chk("R8 read data", b, exp_app);
    end
    chk("R8 released after nack", sda_oe, 1'b0);
    if (end_stop) begin
      bus_stop();
      chk("R7 stop after read", chan_en, exp_app);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    chk("R1 reset chan_en", chan_en, 8'h00);
    chk("R1 reset sda_oe", sda_oe, 1'b0);
    rst_n = 1'b1;
    half();
    chk("R1 idle chan_en", chan_en, 8'h00);

    // R5: bit mapping and extremes
    write_txn(TGT, 1, 24'h0000A5, 1'b1);
    chk("R5 pattern A5", chan_en, 8'hA5);
    write_txn(TGT, 1, 24'h0000FF, 1'b1);
    chk("R5 all on", chan_en, 8'hFF);
    write_txn(TGT, 1, 24'h000000, 1'b1);
    chk("R5 all off", chan_en, 8'h00);

    // R6: last of three bytes wins
    write_txn(TGT, 3, 24'h3C2211, 1'b1);
    chk("R6 last byte", chan_en, 8'h3C);

    // R3: wrong address ignored through stop
    write_txn(7'h71, 2, 24'h0055AA, 1'b1);
    chk("R3 unchanged", chan_en, 8'h3C);

    // R7: pending survives repeated start, read shows applied value
    write_txn(TGT, 1, 24'h000081, 1'b0);
    read_txn(1, 1'b0);
    chk("R7 not applied on restart", chan_en, 8'h3C);
    bus_stop();
    chk("R7 applied at stop", chan_en, 8'h81);

    // R8: ACK then NACK on multi-byte read
    read_txn(3, 1'b1);

    for (int t = 0; t < 40; t++) begin
      int kind;
      kind = $urandom_range(0, 3);
      if (kind == 0) read_txn($urandom_range(1, 2), $urandom_range(0, 1) == 1);
      else write_txn(($urandom_range(0, 3) == 0) ? 7'($urandom_range(0, 127) | 1) ^ TGT ^ 7'h01 ^ 7'h01 : TGT,
                     $urandom_range(1, 3), 24'($urandom), $urandom_range(0, 2) != 0);
    end
    bus_stop();
    chk("R4 final apply", chan_en, exp_app);
    chk("R9 sda_oe moved only with SCL low", n_r9_bad, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule